// File: doc/BRIEF.md
# Sync-Restartable Edge-Aligned PWM Slice

This block is a single edge-aligned PWM timer whose phase can be pinned to an external cycle clock. A prescaled up-counter runs from zero to an active period value and wraps, repeating forever. While the count is at or above an active compare value the primary output is high. A second output carries the complement of that state. A rising edge on the asynchronous sync input clears the counter and the prescaler, so the next period starts from zero no matter where the old one stood. Repeated pulses keep the PWM train locked to whatever produces them.

New period and compare values are written into shadow copies. They reach the active registers only when the counter wraps, so a running period is never cut by a change. A one-cycle interrupt pulse can be placed either on the wrap or on the up-count compare hit. The compare hit lands mid-period when the compare value is about half the period, for example 288 against a period of 575.

Top module: `spwm_slice`

## Requirements
- R1: After reset both PWM outputs and `irq` are low, and the active and shadow period and compare registers hold `PER_RST` (575) and `CMP_RST` (288).
- R2: The counter only counts up. One tick after it equals the active period it returns to zero, so one PWM period lasts (period+1)·(psc_div+1) clock cycles.
- R3: The counter advances once every `psc_div`+1 clock cycles. The prescaler restarts from zero on a sync clear, so the first count after a sync with `psc_div`=2 comes 3 cycles after the clear.
- R4: `sync_in` is synchronized through two flops. The clock edge that first samples it high is edge S, and counter and prescaler read zero after edge S+2. This clear happens once per rising edge however long `sync_in` stays high, and it also happens while `run_en` is low.
- R5: While `run_en` is high, `pwm_out` is 1 when the count is at or above the active compare value. A compare value of 0 gives a constant 1, and a compare value above the period gives a constant 0.
- R6: While `run_en` is high, `pwm_out_n` is the complement of `pwm_out`. The two outputs are never high together.
- R7: While `run_en` is low the counter and prescaler hold their values, both outputs are 0 and `irq` stays 0. Counting resumes from the held value when `run_en` returns high.
- R8: When `shd_we` is high, `shd_sel`=0 writes `shd_wdata` into the period shadow and `shd_sel`=1 writes it into the compare shadow. The active registers take both shadows only on the tick where the counter wraps.
- R9: When a sync clear and a wrap fall in the same cycle, the clear wins. The counter goes to zero and the active registers keep their old values.
- R10: `irq` is a one-cycle pulse. With `irq_sel`=1 it is high in the cycle the counter first holds the compare value after counting up, which is the cycle `pwm_out` rises. With `irq_sel`=0 it is high in the cycle after a wrap. A sync clear never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Counting enable; low forces passive outputs |
| sync_in | input | 1 | Asynchronous sync pulse; rising edge clears and restarts |
| shd_we | input | 1 | Shadow register write strobe |
| shd_sel | input | 1 | Shadow select: 0 period, 1 compare |
| shd_wdata | input | CNT_W | Shadow write value |
| psc_div | input | PSC_W | Prescaler divide value; tick every psc_div+1 clocks |
| irq_sel | input | 1 | Interrupt source: 0 wrap, 1 compare hit counting up |
| pwm_out | output | 1 | Primary PWM output, passive low |
| pwm_out_n | output | 1 | Complementary PWM output, passive low |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench keeps the default parameters: a 10-bit counter, an 8-bit prescaler, two sync stages and the 575/288 reset values. Starting from reset therefore runs one full 576-cycle period at 50 % duty. Shadow writes of short periods (19 and 9) then make mid-period syncs, a sync that falls on a wrap, a disable hold and a divide-by-3 prescaler all reachable within a few hundred cycles. The bench computes every interrupt arrival cycle in advance from the formulas in the requirements, and a monitor matches each pulse it sees against that list.

// File: rtl/spwm_pkg.sv
// Shared types for the sync-restartable PWM slice.
package spwm_pkg;
    // Selects which counter event raises the interrupt pulse.
    typedef enum logic {
        IRQ_ON_WRAP    = 1'b0,
        IRQ_ON_CMP_UP  = 1'b1
    } irq_src_e;

    // Per-cycle counter events, valid in the cycle before the counter updates.
    typedef struct packed {
        logic wrap;     // tick while count equals period
        logic cmp_up;   // tick that increments count onto compare
    } cnt_evt_t;
endpackage

// File: rtl/spwm_sync_edge.sv
// Synchronizes an asynchronous level through STAGES flops and flags its
// rising edge for one cycle. Assumes STAGES >= 2.
module spwm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the input through the synchronizer and remember the last output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    // R4: one clear per rising edge, never two cycles in a row
    p_one_clear_per_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/spwm_prescaler.sv
// Clock divider producing one counter tick every div+1 cycles while enabled.
// A clear restarts the division from zero and suppresses that cycle's tick.
module spwm_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             clr,
    input  logic [PSC_W-1:0] div,
    output logic             tick_o
);
    logic [PSC_W-1:0] psc_q;

    assign tick_o = run_en & ~clr & (psc_q >= div);

    // Advance the divider; hold while disabled, restart on clear or tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (clr || tick_o) begin
            psc_q <= '0;
        end else if (run_en) begin
            psc_q <= psc_q + 1'b1;
        end
    end

    // R3: a clear leaves the divider at zero
    p_psc_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> psc_q == '0);
    // R7: disabled divider does not move
    p_psc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clr) |=> $stable(psc_q));
endmodule

// File: rtl/spwm_counter.sv
// Edge-aligned up-counter with double-buffered period and compare registers.
// Shadows load into the active copies only on a wrap tick; a clear has
// priority over ticks and blocks that cycle's transfer.
module spwm_counter
    import spwm_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int PER_RST = 575,
    parameter int CMP_RST = 288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic             shd_we,
    input  logic             shd_sel,
    input  logic [CNT_W-1:0] shd_wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output cnt_evt_t         evt_o
);
    localparam logic [CNT_W-1:0] PerInit = CNT_W'(PER_RST);
    localparam logic [CNT_W-1:0] CmpInit = CNT_W'(CMP_RST);

    logic [CNT_W-1:0] cnt_q, per_act, cmp_act, per_shd, cmp_shd, cnt_inc;
    logic             at_per;

    assign at_per       = (cnt_q == per_act);
    assign cnt_inc      = cnt_q + 1'b1;
    assign evt_o.wrap   = tick & ~clr & at_per;
    assign evt_o.cmp_up = tick & ~clr & ~at_per & (cnt_inc == cmp_act);
    assign cnt_o        = cnt_q;
    assign cmp_o        = cmp_act;

    // Capture software values into the shadow copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_shd <= PerInit;
            cmp_shd <= CmpInit;
        end else if (shd_we) begin
            if (shd_sel) cmp_shd <= shd_wdata;
            else         per_shd <= shd_wdata;
        end
    end

    // Count, wrap, and transfer shadows on the wrap tick only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            per_act <= PerInit;
            cmp_act <= CmpInit;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (at_per) begin
                cnt_q   <= '0;
                per_act <= per_shd;
                cmp_act <= cmp_shd;
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end

    // R2: count never exceeds the active period
    p_cnt_within_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_act);
    // R4: a clear lands the counter on zero
    p_clear_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
    // R7: without a tick or clear the count holds
    p_hold_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt_q));
    // R8: active registers change only after a wrap
    p_transfer_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_o.wrap |=> ($stable(per_act) && $stable(cmp_act)));
    // R9: clear blocks the transfer
    p_clear_keeps_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ($stable(per_act) && $stable(cmp_act)));
endmodule

// File: rtl/spwm_slice.sv
// Top of the sync-restartable PWM slice: synchronizer, prescaler, counter,
// output stage and interrupt register. Outputs are combinational from the
// count, compare and run enable; irq is registered with the counter update.
module spwm_slice
    import spwm_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PER_RST     = 575,
    parameter int CMP_RST     = 288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             sync_in,
    input  logic             shd_we,
    input  logic             shd_sel,
    input  logic [CNT_W-1:0] shd_wdata,
    input  logic [PSC_W-1:0] psc_div,
    input  logic             irq_sel,
    output logic             pwm_out,
    output logic             pwm_out_n,
    output logic             irq
);
    logic             sync_rise, tick;
    logic [CNT_W-1:0] cnt, cmp_act;
    cnt_evt_t         evt;
    irq_src_e         irq_src;
    logic             pwm_act, irq_q;

    spwm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sync_in), .rise_o(sync_rise)
    );

    spwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr(sync_rise),
        .div(psc_div), .tick_o(tick)
    );

    spwm_counter #(.CNT_W(CNT_W), .PER_RST(PER_RST), .CMP_RST(CMP_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(sync_rise),
        .shd_we(shd_we), .shd_sel(shd_sel), .shd_wdata(shd_wdata),
        .cnt_o(cnt), .cmp_o(cmp_act), .evt_o(evt)
    );

    assign irq_src   = irq_src_e'(irq_sel);
    assign pwm_act   = (cnt >= cmp_act);
    assign pwm_out   = run_en & pwm_act;
    assign pwm_out_n = run_en & ~pwm_act;
    assign irq       = irq_q;

    // Register the selected counter event as a one-cycle interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= (irq_src == IRQ_ON_CMP_UP) ? evt.cmp_up : evt.wrap;
        end
    end

    // R6: complementary outputs never both active
    p_outputs_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_out && pwm_out_n));
    // R7: interrupt only follows an enabled cycle
    p_irq_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(run_en));
    // R10: compare interrupt coincides with the primary output rising
    p_cmp_irq_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && run_en && irq_sel && $past(irq_sel) && $past(run_en))
            |-> (pwm_out && !$past(pwm_out)));
endmodule

// File: tb/spwm_slice_tb_top.sv
// Scoreboard bench: the stimulus sequence pushes the expected interrupt cycles
// into a queue, a negedge monitor pops one per observed pulse and compares.
module spwm_slice_tb_top;
    localparam int CW = 10;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n, run_en, sync_in, shd_we, shd_sel, irq_sel;
    logic [CW-1:0] shd_wdata;
    logic [PW-1:0] psc_div;
    logic          pwm_out, pwm_out_n, irq;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int exp_q[$];
    int e_cyc;
    bit done = 1'b0;
    int c0, e1, e2, e3, e4, rn;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spwm_slice dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .sync_in(sync_in),
        .shd_we(shd_we), .shd_sel(shd_sel), .shd_wdata(shd_wdata),
        .psc_div(psc_div), .irq_sel(irq_sel),
        .pwm_out(pwm_out), .pwm_out_n(pwm_out_n), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d", req, act, exp, cyc);
        end
    endtask

    // Compare {pwm_out,pwm_out_n} as a two-bit value.
    task automatic chk_pwm(input string req, input bit p, input bit n);
        chk({pwm_out, pwm_out_n} == {p, n}, req, int'({pwm_out, pwm_out_n}), int'({p, n}));
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic shadow_write(input bit sel, input int val);
        shd_we = 1'b1; shd_sel = sel; shd_wdata = val[CW-1:0];
        @(negedge clk);
        shd_we = 1'b0;
    endtask

    // Called at negedge cyc=k: sampled high at edges k+1..k+3, clear at k+3.
    task automatic sync_pulse();
        sync_in = 1'b1;
        repeat (3) @(negedge clk);
        sync_in = 1'b0;
    endtask

    // Monitor: every irq pulse must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && irq === 1'b1 && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected irq", cyc, -1);
            end else begin
                e_cyc = exp_q.pop_front();
                chk(cyc == e_cyc, "R2/R10 irq cycle", cyc, e_cyc);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; run_en = 1'b0; sync_in = 1'b0; shd_we = 1'b0;
        shd_sel = 1'b0; shd_wdata = '0; irq_sel = 1'b1; psc_div = '0;
        repeat (3) @(negedge clk);
        chk_pwm("R1 outputs in reset", 1'b0, 1'b0);
        chk(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk_pwm("R7 disabled after reset", 1'b0, 1'b0);

        // R1/R4: enable and sync together; reset compare 288, period 575.
        c0 = cyc; e1 = c0 + 3;
        exp_q.push_back(e1 + 288);
        run_en = 1'b1;
        sync_pulse();
        e2 = e1 + 576;
        e3 = e2 + 82;
        e4 = e3 + 40;
        exp_q.push_back(e2 + 5);  exp_q.push_back(e2 + 25);
        exp_q.push_back(e2 + 45); exp_q.push_back(e2 + 72);
        exp_q.push_back(e3 + 5);  exp_q.push_back(e3 + 25);
        exp_q.push_back(e4 + 5);  exp_q.push_back(e4 + 23);
        exp_q.push_back(e4 + 33); exp_q.push_back(e4 + 43);
        wait_until(e1 + 99);
        shadow_write(1'b0, 19);    // R8 period shadow
        shadow_write(1'b1, 5);     // R8 compare shadow
        wait_until(e1 + 287);
        chk_pwm("R5 R6 below compare", 1'b0, 1'b1);
        wait_until(e1 + 288);
        chk_pwm("R5 R6 at compare", 1'b1, 1'b0);
        wait_until(e2);
        chk_pwm("R2 wrap to zero", 1'b0, 1'b1);
        wait_until(e2 + 5);
        chk_pwm("R8 new compare after wrap", 1'b1, 1'b0);

        // R7: hold for 7 edges, irq shifts by 7.
        wait_until(e2 + 50);
        run_en = 1'b0;
        wait_until(e2 + 54);
        chk_pwm("R7 passive while disabled", 1'b0, 1'b0);
        wait_until(e2 + 57);
        run_en = 1'b1;

        // R4: mid-period sync with count at 15.
        wait_until(e3 - 3);
        sync_in = 1'b1;
        wait_until(e3 - 1);
        chk_pwm("R4 before clear", 1'b1, 1'b0);
        wait_until(e3);
        sync_in = 1'b0;
        chk_pwm("R4 cleared by sync", 1'b0, 1'b1);

        // R9: sync lands on a wrap; new shadows must wait one more period.
        wait_until(e3 + 30);
        shadow_write(1'b0, 9);
        shadow_write(1'b1, 3);
        wait_until(e4 - 3);
        sync_pulse();
        wait_until(e4 + 4);
        chk_pwm("R9 old compare kept after clear", 1'b0, 1'b1);
        wait_until(e4 + 23);
        chk_pwm("R9 transfer on next wrap", 1'b1, 1'b0);

        // R3/R4: sync while disabled, divide by 3, interrupt on wrap.
        wait_until(e4 + 45);
        run_en = 1'b0; irq_sel = 1'b0; psc_div = 8'd2;
        sync_pulse();
        chk_pwm("R7 passive after disable", 1'b0, 1'b0);
        rn = e4 + 55;
        exp_q.push_back(rn + 30); exp_q.push_back(rn + 60); exp_q.push_back(rn + 90);
        wait_until(rn);
        run_en = 1'b1;
        wait_until(rn + 8);
        chk_pwm("R3 count 2 below compare 3", 1'b0, 1'b1);
        wait_until(rn + 9);
        chk_pwm("R3 count 3 reaches compare", 1'b1, 1'b0);

        // R5 boundaries: compare 0 then compare above period.
        wait_until(rn + 35);
        shadow_write(1'b1, 0);
        wait_until(rn + 61);
        chk_pwm("R5 compare zero full duty", 1'b1, 1'b0);
        shadow_write(1'b1, 12);
        wait_until(rn + 75);
        chk_pwm("R5 compare zero full duty late", 1'b1, 1'b0);
        wait_until(rn + 91);
        chk_pwm("R5 compare above period zero duty", 1'b0, 1'b1);
        wait_until(rn + 100);
        chk_pwm("R5 compare above period zero duty late", 1'b0, 1'b1);

        wait_until(rn + 101);
        run_en = 1'b0;
        repeat (30) @(negedge clk);
        chk_pwm("R7 final passive", 1'b0, 1'b0);
        chk(exp_q.size() == 0, "R10 all expected irqs seen", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule